// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the programming word of a frequency synthesizer: a 9-bit feedback divide value, a 3-bit output divide code and a 2-bit test-select field. The word can come from two sources. In parallel mode a set of static configuration pins drives it under a level-sensitive load strobe. In serial mode a 14-bit frame is shifted in on a slow serial clock and then committed by a separate load strobe. A serial commit and a parallel load each take over from the other.

All serial and strobe inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are found by comparing the result with the previous sample. For this to work, the system clock must run at least four times faster than the serial clock. The block also drives a test pin whose source is chosen by the test-select field. It raises a sticky flag when a feedback divide value outside the lockable range is loaded. The analog loop and the dividers themselves sit outside the block.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset the test field is 00, the out-of-range flag is 0, test_o is low, and, with the parallel strobe low, m_o/n_o follow the pins within 6 system clocks.
- R2: While pload_ni is low, m_o and n_o track m_pins_i and n_pins_i, t_o keeps its value, and test_o is forced low whatever the test field selects.
- R3: A rising edge of pload_ni captures the pins. Later pin changes have no effect on m_o/n_o while pload_ni stays high.
- R4: The serial frame is 14 bits, sent MSB first, in the order t[1], t[0], n[2..0], m[8..0]. Frame bits 13:12 form the test field, bits 11:9 form n and bits 8:0 form m. A rising edge of sload_i, with pload_ni high, copies the shift register to t_o/n_o/m_o.
- R5: A rising sclk_i edge with pload_ni high and sload_i low shifts sdata_i into the shift register and leaves t_o/n_o/m_o unchanged.
- R6: While sload_i is held high, each rising sclk_i edge shifts and also updates t_o/n_o/m_o to the new shift-register contents.
- R7: After sload_i falls, further serial shifts no longer alter the active values.
- R8: test_o selection by t_o: 00 gives low, 01 gives sdata_i, 10 gives mdiv_tap_i, 11 gives fout_tap_i.
- R9: mr_i leaves m_o, n_o and t_o unchanged. While mr_i is high, the selections 10 and 11 drive test_o low.
- R10: Loading an m value below 250 or above 500 still loads that value and sets out_of_range_o. The flag then stays set until reset.
- R11: After a serial commit, pin changes are ignored until pload_ni goes low. From then on the pins drive m_o/n_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdata_i | input | 1 | Serial data, sampled on rising sclk_i |
| sload_i | input | 1 | Serial commit/transparent strobe |
| pload_ni | input | 1 | Parallel load strobe, low = parallel pass-through |
| m_pins_i | input | 9 | Parallel feedback divide value |
| n_pins_i | input | 3 | Parallel output divide code |
| mr_i | input | 1 | Divider reset indication |
| mdiv_tap_i | input | 1 | Feedback divider output tap |
| fout_tap_i | input | 1 | Synthesized output clock tap |
| m_o | output | 9 | Active feedback divide value |
| n_o | output | 3 | Active output divide code |
| t_o | output | 2 | Active test-select field |
| test_o | output | 1 | Test pin |
| out_of_range_o | output | 1 | Sticky flag for an unlockable m value |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and a lock range of 250 to 500. With these values, serial clock phases of four system clocks are long enough for every edge to be seen. Random frames drawn from 250 to 500 keep the flag clear, which leaves a directed value of 100 to show both the sticky behaviour and the fact that the value is still loaded. The default range also exposes the intermediate out-of-range words that appear during transparent shifting.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned M_W     = 9;
  localparam int unsigned N_W     = 3;
  localparam int unsigned T_W     = 2;
  localparam int unsigned FRAME_W = T_W + N_W + M_W;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_MDIV  = 2'b10,
    TSEL_FOUT  = 2'b11
  } test_sel_e;

  // Field order matches the serial frame, MSB first.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] sr_q;

  assign nxt_o = {sr_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= nxt_o;
  end

  assign q_o = sr_q;
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import cfg_loader_pkg::*;
(
  input  test_sel_e sel_i,
  input  logic      par_mode_i,
  input  logic      mr_i,
  input  logic      sdata_i,
  input  logic      mdiv_i,
  input  logic      fout_i,
  output logic      test_o
);
  always_comb begin
    test_o = 1'b0;
    if (!par_mode_i) begin
      unique case (sel_i)
        TSEL_LOW:   test_o = 1'b0;
        TSEL_SDATA: test_o = sdata_i;
        TSEL_MDIV:  test_o = mdiv_i & ~mr_i;  // dividers held low in reset
        TSEL_FOUT:  test_o = fout_i & ~mr_i;
        default:    test_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned M_MIN       = 250,
  parameter int unsigned M_MAX       = 500
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sload_i,
  input  logic           pload_ni,
  input  logic [M_W-1:0] m_pins_i,
  input  logic [N_W-1:0] n_pins_i,
  input  logic           mr_i,
  input  logic           mdiv_tap_i,
  input  logic           fout_tap_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           test_o,
  output logic           out_of_range_o
);
  localparam int unsigned NSYNC    = 4;
  localparam int unsigned NCTL     = 3;
  localparam int unsigned IX_SCLK  = 0;
  localparam int unsigned IX_SLOAD = 1;
  localparam int unsigned IX_PLOAD = 2;
  localparam int unsigned IX_SDATA = 3;
  localparam logic [M_W-1:0] M_LO  = M_MIN[M_W-1:0];
  localparam logic [M_W-1:0] M_HI  = M_MAX[M_W-1:0];

  logic [NSYNC-1:0] raw, syn;
  logic [NCTL-1:0]  ctl_prev;

  assign raw = {sdata_i, pload_ni, sload_i, sclk_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    cfg_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (syn[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_prev <= '0;
    else         ctl_prev <= syn[NCTL-1:0];
  end

  logic sc_q, sc_d, sl_q, sl_d, pl_q, pl_d;
  assign sc_q = syn[IX_SCLK];
  assign sc_d = ctl_prev[IX_SCLK];
  assign sl_q = syn[IX_SLOAD];
  assign sl_d = ctl_prev[IX_SLOAD];
  assign pl_q = syn[IX_PLOAD];
  assign pl_d = ctl_prev[IX_PLOAD];

  logic shift_en;
  assign shift_en = pl_q & sc_q & ~sc_d;

  logic [FRAME_W-1:0] sr_q, sr_nxt;

  cfg_shifter #(.W(FRAME_W)) i_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .bit_i (syn[IX_SDATA]),
    .q_o   (sr_q),
    .nxt_o (sr_nxt)
  );

  cfg_word_t word_q, word_d;
  logic      load, oor_q;

  // Priority: parallel mode / parallel latch edge, serial commit, transparent shift.
  always_comb begin
    word_d = word_q;
    load   = 1'b0;
    if (!pl_q || !pl_d) begin
      word_d.m = m_pins_i;
      word_d.n = n_pins_i;
      load     = 1'b1;
    end else if (sl_q && !sl_d) begin
      word_d = cfg_word_t'(sr_q);
      load   = 1'b1;
    end else if (sl_q && shift_en) begin
      word_d = cfg_word_t'(sr_nxt);
      load   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q.t <= '0;
      word_q.n <= '0;
      word_q.m <= M_LO;
      oor_q    <= 1'b0;
    end else begin
      word_q <= word_d;
      if (load && (word_d.m < M_LO || word_d.m > M_HI)) oor_q <= 1'b1;
    end
  end

  cfg_test_mux i_tmux (
    .sel_i     (test_sel_e'(word_q.t)),
    .par_mode_i(~pl_q),
    .mr_i      (mr_i),
    .sdata_i   (sdata_i),
    .mdiv_i    (mdiv_tap_i),
    .fout_i    (fout_tap_i),
    .test_o    (test_o)
  );

  assign m_o            = word_q.m;
  assign n_o            = word_q.n;
  assign t_o            = word_q.t;
  assign out_of_range_o = oor_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_loader_pkg::*;
#(
  parameter int unsigned M_MIN = 250,
  parameter int unsigned M_MAX = 500
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pl_q_i,
  input logic               pl_d_i,
  input logic               sl_q_i,
  input logic               sl_d_i,
  input logic [FRAME_W-1:0] sr_i,
  input cfg_word_t          word_i,
  input logic [M_W-1:0]     m_pins_i,
  input logic               test_i,
  input logic               oor_i
);
  localparam logic [M_W-1:0] M_LO = M_MIN[M_W-1:0];
  localparam logic [M_W-1:0] M_HI = M_MAX[M_W-1:0];

  assert_test_low_parallel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pl_q_i |-> !test_i);

  assert_latch_pins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_q_i && !pl_d_i) |=> (word_i.m == $past(m_pins_i)));

  assert_commit_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_q_i && pl_d_i && sl_q_i && !sl_d_i) |=> (word_i == cfg_word_t'($past(sr_i))));

  // Covers R7 as well: once the strobe is low, shifting leaves the word alone.
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_q_i && pl_d_i && !sl_q_i && !sl_d_i) |=> $stable(word_i));

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_i |=> oor_i);

  assert_flag_on_bad_m_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i.m < M_LO || word_i.m > M_HI) |-> oor_i);
endmodule

bind synth_cfg_loader cfg_loader_chk #(.M_MIN(M_MIN), .M_MAX(M_MAX)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pl_q_i  (pl_q),
  .pl_d_i  (pl_d),
  .sl_q_i  (sl_q),
  .sl_d_i  (sl_d),
  .sr_i    (sr_q),
  .word_i  (word_q),
  .m_pins_i(m_pins_i),
  .test_i  (test_o),
  .oor_i   (oor_q)
);

// File: tb/test_synth_cfg_loader.sv
module test_synth_cfg_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk, sdata, sload, pload_n, mr, tmdiv, tfout;
  logic [8:0] mp;
  logic [2:0] np;
  logic [8:0] m_o;
  logic [2:0] n_o;
  logic [1:0] t_o;
  logic test_o, oor_o;

  int n_checks = 0, n_errs = 0;
  logic [13:0] e_sr, e_word;
  logic e_oor;

  always #5 clk = ~clk;

  synth_cfg_loader i_synth_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .pload_ni(pload_n), .m_pins_i(mp), .n_pins_i(np), .mr_i(mr),
    .mdiv_tap_i(tmdiv), .fout_tap_i(tfout), .m_o(m_o), .n_o(n_o), .t_o(t_o),
    .test_o(test_o), .out_of_range_o(oor_o)
  );

  function automatic logic exp_test(logic [1:0] t, logic pl_n, logic mr_v,
                                    logic sd, logic md, logic fo);
    if (!pl_n) return 1'b0;
    case (t)
      2'b00:   return 1'b0;
      2'b01:   return sd;
      2'b10:   return md & ~mr_v;
      default: return fo & ~mr_v;
    endcase
  endfunction

  task automatic upd_word(logic [13:0] w);
    e_word = w;
    if (w[8:0] < 9'd250 || w[8:0] > 9'd500) e_oor = 1'b1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_word(string tag);
    check(tag, {18'd0, t_o, n_o, m_o}, {18'd0, e_word});
    check({tag, " flag"}, {31'd0, oor_o}, {31'd0, e_oor});
  endtask

  task automatic check_test(string tag);
    wait_n(1);
    check({tag, " test"}, {31'd0, test_o},
          {31'd0, exp_test(e_word[13:12], pload_n, mr, sdata, tmdiv, tfout)});
  endtask

  task automatic set_pins(logic [8:0] m, logic [2:0] n);
    mp = m; np = n;
    wait_n(6);
    if (!pload_n) upd_word({e_word[13:12], n, m});
  endtask

  task automatic set_pload(logic v);
    logic prev = pload_n;
    pload_n = v;
    wait_n(6);
    if (!v || !prev) upd_word({e_word[13:12], np, mp});
  endtask

  task automatic shift_bit(logic b);
    sdata = b;
    wait_n(4);
    sclk = 1'b1;
    wait_n(4);
    sclk = 1'b0;
    wait_n(4);
    if (pload_n) begin
      e_sr = {e_sr[12:0], b};
      if (sload) upd_word(e_sr);
    end
  endtask

  task automatic send_frame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic set_sload(logic v);
    logic prev = sload;
    sload = v;
    wait_n(6);
    if (v && !prev && pload_n) upd_word(e_sr);
  endtask

  task automatic commit(logic [13:0] f);
    send_frame(f);
    set_sload(1'b1);
    set_sload(1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    sclk = 0; sdata = 0; sload = 0; pload_n = 0; mr = 0; tmdiv = 0; tfout = 0;
    mp = 9'd300; np = 3'd2;
    e_sr = '0; e_word = {2'b00, 3'd2, 9'd300}; e_oor = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);

    // R1: reset state, pins followed
    check_word("R1");
    check("R1 test", {31'd0, test_o}, 32'd0);

    // R2: parallel pass-through, test forced low
    set_pins(9'd420, 3'd5);
    check_word("R2");
    sdata = 1'b1; tfout = 1'b1; tmdiv = 1'b1;
    check_test("R2");

    // R3: latch on rising strobe, later pins ignored
    set_pload(1'b1);
    set_pins(9'd260, 3'd1);
    check_word("R3");

    // R5: shifting with serial strobe low leaves the word alone
    send_frame({2'b01, 3'd6, 9'd377});
    check_word("R5");

    // R4: commit
    set_sload(1'b1);
    set_sload(1'b0);
    check_word("R4");

    // R11: serial load holds against pins until parallel mode resumes
    set_pins(9'd333, 3'd3);
    check_word("R11 hold");
    set_pload(1'b0);
    check_word("R11 resume");
    set_pload(1'b1);

    // R4 and R8: random in-range frames and random taps
    for (int k = 0; k < 8; k++) begin
      logic [13:0] f;
      f = {2'($urandom), 3'($urandom), 9'(250 + ($urandom % 251))};
      commit(f);
      check_word("R4 random");
      sdata = 1'($urandom); tmdiv = 1'($urandom); tfout = 1'($urandom);
      check_test("R8 random");
    end

    // R8: each selection, directed
    for (int s = 0; s < 4; s++) begin
      commit({2'(s), 3'd4, 9'd480});
      sdata = 1'b1; tmdiv = 1'b0; tfout = 1'b1;
      check_test("R8 sel");
      sdata = 1'b0; tmdiv = 1'b1; tfout = 1'b0;
      check_test("R8 sel");
    end

    // R2: parallel mode forces test low even with selection 11
    set_pload(1'b0);
    tfout = 1'b1;
    check_test("R2 sel11");
    set_pload(1'b1);

    // R9: divider reset has no effect on stored values
    commit({2'b10, 3'd7, 9'd500});
    mr = 1'b1; tmdiv = 1'b1;
    wait_n(6);
    check_word("R9");
    check_test("R9");
    mr = 1'b0;
    wait_n(6);
    check_word("R9 after");
    check_test("R9 after");

    // R10: out-of-range value loaded, flag sticky
    check("R10 clear", {31'd0, oor_o}, 32'd0);
    commit({2'b00, 3'd0, 9'd100});
    check_word("R10 set");
    check("R10 m", {23'd0, m_o}, 32'd100);
    commit({2'b00, 3'd1, 9'd250});
    check_word("R10 sticky");

    // R6: transparent while strobe held high
    set_sload(1'b1);
    check_word("R6 enter");
    for (int b = 0; b < 3; b++) begin
      shift_bit(1'($urandom));
      check_word("R6 shift");
    end

    // R7: latched after strobe falls
    set_sload(1'b0);
    for (int b = 0; b < 5; b++) shift_bit(1'($urandom));
    check_word("R7");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule